// File: doc/BRIEF.md
# Down-Spread Frequency Modulation Controller

This block generates the instantaneous control word for a fractional-N feedback divider so that one synthesized clock is swept below its nominal frequency in a symmetric triangular pattern. It runs from the reference clock. On every cycle it subtracts a time-varying offset from a nominal divider word, which is fixed point with 24 fractional bits. The offset ramps linearly from zero up to a peak and back to zero once per modulation period. The output never rises above the nominal word.

A 3-bit select code chooses the peak depth in steps of 0.5 % of the nominal word. Several code values mean "no spread". A new code is adopted only at the top of the triangle, where the offset is zero, so the frequency never steps. An enable input gates the whole loop. When it is cleared, a power-down flag rises in the same cycle and the offset is held at zero. When the enable returns, the sweep restarts from zero offset.

With the default half period of 428 cycles, one sweep lasts 856 reference cycles. That is about 31.5 kHz from a 27 MHz reference.

Top module: `spread_mod_ctrl`

## Requirements
- R1: While reset is held low and out_en is high, div_word equals nom_word and pll_pd is 0.
- R2: Select codes 3'b000, 3'b011, 3'b101 and 3'b111 give no spread: div_word equals nom_word on every cycle.
- R3: Code 3'b001 gives a peak offset of 0.5 % of nom_word (nom_word/200). The measured peak lies in [ideal − 2·HALF_CYC, ideal] and never above the ideal.
- R4: Code 3'b010 gives a peak offset of 1.0 % of nom_word, with the same bounds as R3.
- R5: Code 3'b100 gives a peak offset of 2.0 % of nom_word, with the same bounds as R3.
- R6: Code 3'b110 gives a peak offset of 3.0 % of nom_word, with the same bounds as R3.
- R7: div_word never exceeds nom_word.
- R8: The sweep is a symmetric triangle. The offset is zero at the top, and the next zero comes 2·HALF_CYC cycles later. The deepest point comes exactly HALF_CYC cycles after the top.
- R9: A change of spread_sel made during a sweep leaves that sweep's depth unchanged. The new depth applies from the next top onward.
- R10: pll_pd equals 1 in the same cycle that out_en is 0. While out_en is 0, div_word equals nom_word.
- R11: After out_en returns to 1, the sweep restarts from zero offset. The first offset is seen one cycle later, and the next top comes 2·HALF_CYC cycles after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spread_sel | input | 3 | Spread depth select code |
| out_en | input | 1 | Output and loop enable |
| nom_word | input | WORD_W | Nominal divider word (24 fractional bits) |
| div_word | output | WORD_W | Instantaneous divider word |
| pll_pd | output | 1 | PLL power-down request |

## Verification
pll_pd follows out_en in the same cycle. The bench therefore checks it one time unit after driving the enable, before the next edge.

div_word is taken without logic from the registered offset. Any change in the offset shows one rising edge after the inputs that caused it. The bench samples every result on the falling edge that follows that rising edge.

A new select code is adopted only at the top of the triangle. Before measuring a code, the bench waits one full period plus two cycles. It then locks onto a cycle where div_word equals nom_word and counts the cycles to the deepest point and to the next top, which gives the peak time, the period and the depth.

For re-enable, counting starts at the enable itself. The next top is expected exactly 2·HALF_CYC falling edges later.

// File: rtl/spread_pkg.sv
// Shared constants and code decoding for the down-spread controller.
// Assumes depth is expressed in units of 0.5 % of the nominal word.
package spread_pkg;

    // Divisor turning one depth unit into a fraction of the nominal word (0.5 %)
    localparam int UNIT_DIV = 200;
    localparam int UNIT_W   = 3;

    typedef logic [2:0] spread_code_t;

    // Map a select code to depth units; unlisted codes mean no spread
    function automatic logic [UNIT_W-1:0] code_to_units(input spread_code_t code);
        case (code)
            3'b001:  code_to_units = 3'd1;
            3'b010:  code_to_units = 3'd2;
            3'b100:  code_to_units = 3'd4;
            3'b110:  code_to_units = 3'd6;
            default: code_to_units = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/spread_code_decode.sv
// Decodes the sparse spread select code into a depth in 0.5 % units.
// Assumes: purely combinational; reserved codes decode to zero depth.
module spread_code_decode
    import spread_pkg::*;
(
    input  logic [2:0]        sel,
    output logic [UNIT_W-1:0] units
);

    // Table lookup of depth units
    always_comb begin
        units = code_to_units(sel);
    end

endmodule

// File: rtl/spread_step_calc.sv
// Computes the per-cycle offset increment nom*units/(UNIT_DIV*HALF_CYC).
// Assumes: the divide is replaced by a multiply with a truncated reciprocal
// of SHIFT fractional bits, so the step never exceeds the exact value.
module spread_step_calc
    import spread_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = 428,
    parameter int SHIFT    = 40
) (
    input  logic [WORD_W-1:0] nom,
    input  logic [UNIT_W-1:0] units,
    output logic [WORD_W-1:0] step
);

    localparam int PROD_W = WORD_W + UNIT_W + SHIFT;
    localparam logic [PROD_W-1:0] RECIP =
        (PROD_W'(1) << SHIFT) / PROD_W'(UNIT_DIV * HALF_CYC);

    logic [PROD_W-1:0] prod;

    // Scaled product, then drop the reciprocal's fraction bits
    always_comb begin
        prod = PROD_W'(nom) * PROD_W'(units) * RECIP;
        step = WORD_W'(prod >> SHIFT);
    end

endmodule

// File: rtl/spread_tri_sweep.sv
// Triangle offset generator: the offset rises by one step per cycle for
// HALF_CYC cycles, then falls by the same step for HALF_CYC cycles.
// Assumes: the step is latched only at the top (phase 0) while enabled;
// disabling clears phase and offset so a re-enable restarts from zero.
module spread_tri_sweep #(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = 428
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WORD_W-1:0] new_step,
    output logic [WORD_W-1:0] offset
);

    localparam int PERIOD = 2 * HALF_CYC;
    localparam int CNT_W  = $clog2(PERIOD);

    logic [CNT_W-1:0]  phase;
    logic [WORD_W-1:0] step_r;
    logic [WORD_W-1:0] step_eff;

    // Step in force this cycle: a fresh one at the top, else the held one
    always_comb begin
        step_eff = (phase == '0) ? new_step : step_r;
    end

    // Phase counter, held step and offset accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            step_r <= '0;
            offset <= '0;
        end else if (!en) begin
            phase  <= '0;
            offset <= '0;
        end else begin
            if (phase == '0) begin
                step_r <= new_step;
            end
            if (phase < CNT_W'(HALF_CYC)) begin
                offset <= offset + step_eff;
            end else begin
                offset <= offset - step_eff;
            end
            phase <= (phase == CNT_W'(PERIOD - 1)) ? '0 : phase + 1'b1;
        end
    end

    // R8: the top of the triangle always carries zero offset
    p_top_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0) |-> (offset == '0));

    // R8: phase stays inside one period
    p_phase_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase < CNT_W'(PERIOD));

    // R9: the held step changes only when leaving the top
    p_step_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |=> $stable(step_r));

    // R11: after a disabled cycle the sweep sits at the top with zero offset
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (offset == '0 && phase == '0));

endmodule

// File: rtl/spread_mod_ctrl.sv
// Top of the down-spread controller: decodes the select code, derives the
// per-cycle step and subtracts the triangle offset from the nominal word.
// Assumes: nom_word is held steady while spreading; synchronous active-low reset.
module spread_mod_ctrl
    import spread_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int HALF_CYC = 428,
    parameter int SHIFT    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        spread_sel,
    input  logic              out_en,
    input  logic [WORD_W-1:0] nom_word,
    output logic [WORD_W-1:0] div_word,
    output logic              pll_pd
);

    logic [UNIT_W-1:0] units;
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] offset;

    spread_code_decode u_decode (
        .sel   (spread_sel),
        .units (units)
    );

    spread_step_calc #(
        .WORD_W   (WORD_W),
        .HALF_CYC (HALF_CYC),
        .SHIFT    (SHIFT)
    ) u_step (
        .nom   (nom_word),
        .units (units),
        .step  (step)
    );

    spread_tri_sweep #(
        .WORD_W   (WORD_W),
        .HALF_CYC (HALF_CYC)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (out_en),
        .new_step (step),
        .offset   (offset)
    );

    // Output word and loop power-down request
    always_comb begin
        div_word = nom_word - offset;
        pll_pd   = ~out_en;
    end

    // R7: the swept word never rises above nominal
    p_down_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_word <= nom_word);

endmodule

// File: tb/spread_mod_ctrl_bench.sv
module spread_mod_ctrl_bench;

    localparam int          WORD_W = 32;
    localparam int          HALF   = 428;
    localparam logic [31:0] NOM    = 32'd23_000_000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        spread_sel;
    logic              out_en;
    logic [WORD_W-1:0] nom_word;
    logic [WORD_W-1:0] div_word;
    logic              pll_pd;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spread_mod_ctrl #(.WORD_W(WORD_W), .HALF_CYC(HALF)) u_spread_mod_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .spread_sel (spread_sel),
        .out_en     (out_en),
        .nom_word   (nom_word),
        .div_word   (div_word),
        .pll_pd     (pll_pd)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Walk falling edges until a zero-offset sample (the top) is seen
    task automatic sync_top();
        for (int i = 0; i < 4 * HALF; i++) begin
            @(negedge clk);
            if (div_word == nom_word) break;
        end
    endtask

    // Follow one sweep from just after a top; optionally change the code midway
    task automatic sweep(input int sw_at, input logic [2:0] sw_sel,
                         output longint peak, output int tmin, output int per,
                         output bit above);
        logic [31:0] minv = nom_word;
        int k = 0;
        tmin  = 0;
        above = 1'b0;
        do begin
            @(negedge clk);
            k++;
            if (k == sw_at) spread_sel = sw_sel;
            if (div_word < minv) begin
                minv = div_word;
                tmin = k;
            end
            if (div_word > nom_word) above = 1'b1;
        end while (div_word != nom_word && k < 4 * HALF);
        per  = k;
        peak = longint'(nom_word) - longint'(minv);
    endtask

    task automatic check_depth(input longint peak, input int units, input string req);
        longint ideal = longint'(NOM) * units / 200;
        check(peak <= ideal && peak >= ideal - 2 * HALF, req, peak, ideal);
    endtask

    task automatic t_reset();
        rst_n      = 1'b0;
        out_en     = 1'b1;
        spread_sel = 3'b000;
        nom_word   = NOM;
        repeat (3) @(negedge clk);
        check(div_word == NOM, "R1 div_word in reset", div_word, NOM);
        check(pll_pd == 1'b0, "R1 pll_pd in reset", pll_pd, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_flat(input logic [2:0] code);
        bit ok = 1'b1;
        spread_sel = code;
        repeat (2 * HALF + 2) @(negedge clk);
        for (int i = 0; i < 2 * HALF + 4; i++) begin
            @(negedge clk);
            if (div_word != NOM) ok = 1'b0;
        end
        check(ok, $sformatf("R2 no spread code %0d", code), div_word, NOM);
    endtask

    task automatic t_depth(input logic [2:0] code, input int units, input string req);
        longint peak;
        int tmin, per;
        bit above;
        spread_sel = code;
        repeat (2 * HALF + 2) @(negedge clk);
        sync_top();
        sweep(-1, code, peak, tmin, per, above);
        check_depth(peak, units, req);
        check(per == 2 * HALF, "R8 period", per, 2 * HALF);
        check(tmin == HALF, "R8 deepest point", tmin, HALF);
        check(!above, "R7 never above nominal", above, 0);
    endtask

    task automatic t_switch();
        longint peak;
        int tmin, per;
        bit above;
        spread_sel = 3'b100;
        repeat (2 * HALF + 2) @(negedge clk);
        sync_top();
        sweep(HALF / 2, 3'b001, peak, tmin, per, above);
        check_depth(peak, 4, "R9 old depth kept mid-sweep");
        sweep(-1, 3'b001, peak, tmin, per, above);
        check_depth(peak, 1, "R9 new depth at next top");
    endtask

    task automatic t_enable();
        longint peak;
        int tmin, per;
        bit above;
        bit ok = 1'b1;
        spread_sel = 3'b110;
        repeat (2 * HALF + 2) @(negedge clk);
        sync_top();
        repeat (100) @(negedge clk);
        out_en = 1'b0;
        #1;
        check(pll_pd == 1'b1, "R10 pll_pd same cycle", pll_pd, 1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (div_word != NOM || pll_pd != 1'b1) ok = 1'b0;
        end
        check(ok, "R10 zero offset while disabled", div_word, NOM);
        out_en = 1'b1;
        #1;
        check(pll_pd == 1'b0, "R10 pll_pd released", pll_pd, 0);
        sweep(-1, 3'b110, peak, tmin, per, above);
        check(per == 2 * HALF, "R11 restart top timing", per, 2 * HALF);
        check(tmin == HALF, "R11 restart deepest point", tmin, HALF);
        check_depth(peak, 6, "R11 restart depth");
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_flat(3'b000);
        t_depth(3'b001, 1, "R3 depth 0.5%");
        t_depth(3'b010, 2, "R4 depth 1.0%");
        t_flat(3'b011);
        t_depth(3'b100, 4, "R5 depth 2.0%");
        t_flat(3'b101);
        t_depth(3'b110, 6, "R6 depth 3.0%");
        t_flat(3'b111);
        t_switch();
        t_enable();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule